// File: doc/BRIEF.md
# Crosspoint Switch Control Register

This block is the digital control path of a crosspoint switch with 8 outputs and 8 inputs. Each output owns a 4-bit code. The low three bits of the code pick one of the eight inputs. The top bit turns that output on or off.

Codes are first collected in a staging register. There are two ways to fill it:
- A serial chain shifts in one bit per clock. Its far end is brought out as a serial output, so several blocks can be chained into one long chain.
- An addressed parallel port rewrites the code of one output and leaves the other seven untouched.

An update strobe copies the whole staging register into a second-rank latch in one step. Only the second rank drives the switch. The switch therefore changes all at once and never passes through a half-programmed state.

The latched codes are decoded into 64 one-hot crosspoint enables, 8 for each output, and 8 output enables. A synchronous reset clears both ranks, which disables every output. All loads and updates are gated by a chip-enable input.

Top module: `xpt_ctrl`

## Requirements
- R1: While `rst` is high, and after it is released, all `xpt_en` bits, all `out_en` bits and `ser_out` are 0.
- R2: With `ce`=1, `ser_mode`=1 and `update`=0, every clock shifts the staging register up by one bit and moves `ser_in` into bit 0. Output k's code occupies staging bits [4k+3:4k]. A word sent output 7 first, MSB first, places every field after 32 clocks.
- R3: `ser_out` always equals staging bit 31, the MSB of output 7's field. After a further 32 shifts, a previously loaded word leaves on `ser_out` in the order in which it was sent.
- R4: With `ce`=1, `ser_mode`=0 and `update`=0, every clock writes `par_data` into the field of output `par_addr` and leaves the other seven fields unchanged.
- R5: Loads into the staging register do not change `xpt_en` or `out_en`.
- R6: With `ce`=1 and `update`=1, the whole staging register is copied to the second rank on the clock edge. No load happens in that cycle. The outputs show the new codes right after that edge.
- R7: For an enabled output k, `out_en[k]`=1 and exactly one of its enables is set: `xpt_en[8k+s]`, where s is the value of code bits [2:0].
- R8: When code bit 3 of output k is 0, `out_en[k]`=0 and `xpt_en[8k+7:8k]` are all 0.
- R9: With `ce`=0, shifts, parallel writes and updates are all ignored, and `ser_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears both ranks |
| ce | input | 1 | Chip enable; loads and updates take effect only when 1 |
| ser_mode | input | 1 | 1 selects serial shifting, 0 selects parallel writes |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Far end of the serial chain, for daisy-chaining |
| par_addr | input | 3 | Output index for parallel writes |
| par_data | input | 4 | Code for parallel writes |
| update | input | 1 | Copies the staging register into the second rank |
| xpt_en | output | 64 | One-hot crosspoint enables, bit 8k+s joins input s to output k |
| out_en | output | 8 | Output enables |

## Verification
A fault in the staging register stays hidden from `xpt_en` and `out_en` until the next update. The bench therefore checks `ser_out` after every shift, since `ser_out` shows staging bit 31 on every cycle. A corrupted field that never reaches bit 31 appears only once an update exposes it, in the cycle right after that update. A fault in the second rank or in the decoders shows at once as a wrong, missing or duplicated enable in the affected output's group of eight.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  parameter int unsigned XPT_OUTS = 8;
  parameter int unsigned XPT_INS  = 8;
endpackage

// File: rtl/xpt_stage.sv
module xpt_stage #(
  parameter int unsigned N_OUT  = 8,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ce,
  input  logic                      ser_mode,
  input  logic                      ser_in,
  input  logic                      update,
  input  logic [ADDR_W-1:0]         par_addr,
  input  logic [CODE_W-1:0]         par_data,
  output logic [N_OUT*CODE_W-1:0]   stage_q,
  output logic                      ser_out
);
  localparam int unsigned TOT = N_OUT * CODE_W;

  logic load;
  assign load = ce && !update;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (load) begin
      if (ser_mode) stage_q <= {stage_q[TOT-2:0], ser_in};
      else          stage_q[par_addr*CODE_W +: CODE_W] <= par_data;
    end
  end

  assign ser_out = stage_q[TOT-1];

  // R2: the serial input lands in bit 0 after a shift
  a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
    (ce && !update && ser_mode) |=> stage_q[0] == $past(ser_in));
  // R2: the remaining bits move up by one position
  a_r2_shift_up: assert property (@(posedge clk) disable iff (rst)
    (ce && !update && ser_mode) |=> stage_q[TOT-1:1] == $past(stage_q[TOT-2:0]));
  // R4: the addressed field takes the parallel data
  a_r4_par_write: assert property (@(posedge clk) disable iff (rst)
    (ce && !update && !ser_mode) |=>
      stage_q[$past(par_addr)*CODE_W +: CODE_W] == $past(par_data));
  // R9: nothing is loaded while chip enable is low
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!ce || update) |=> $stable(stage_q));
endmodule

// File: rtl/xpt_latch.sv
module xpt_latch #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             update,
  input  logic [WIDTH-1:0] stage_q,
  output logic [WIDTH-1:0] latch_q
);
  always_ff @(posedge clk) begin
    if (rst)               latch_q <= '0;
    else if (ce && update) latch_q <= stage_q;
  end

  // R6: an update copies the whole first rank
  a_r6_copy: assert property (@(posedge clk) disable iff (rst)
    (ce && update) |=> latch_q == $past(stage_q));
  // R5: without an update the second rank holds
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !(ce && update) |=> $stable(latch_q));
  // R1: reset clears the second rank
  a_r1_reset: assert property (@(posedge clk)
    rst |=> latch_q == '0);
endmodule

// File: rtl/xpt_decode.sv
module xpt_decode #(
  parameter int unsigned N_OUT = 8,
  parameter int unsigned N_IN  = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic [N_OUT*(SEL_W+1)-1:0] latch_q,
  output logic [N_OUT*N_IN-1:0]      xpt_en,
  output logic [N_OUT-1:0]           out_en
);
  localparam int unsigned CODE_W = SEL_W + 1;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [SEL_W-1:0] sel;
    assign sel       = latch_q[o*CODE_W +: SEL_W];
    assign out_en[o] = latch_q[o*CODE_W + SEL_W];
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      assign xpt_en[o*N_IN + i] = out_en[o] && (sel == SEL_W'(i));
    end
    // R7 and R8: at most one crosspoint per output, none when it is disabled
    always_comb begin
      a_r7_onehot: assert ($onehot0(xpt_en[o*N_IN +: N_IN]));
      a_r8_off: assert (out_en[o] || xpt_en[o*N_IN +: N_IN] == '0);
    end
  end
endmodule

// File: rtl/xpt_ctrl.sv
module xpt_ctrl
  import xpt_pkg::*;
#(
  parameter int unsigned N_OUT = XPT_OUTS,
  parameter int unsigned N_IN  = XPT_INS,
  localparam int unsigned SEL_W  = $clog2(N_IN),
  localparam int unsigned CODE_W = SEL_W + 1,
  localparam int unsigned ADDR_W = $clog2(N_OUT),
  localparam int unsigned TOT    = N_OUT * CODE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce,
  input  logic                  ser_mode,
  input  logic                  ser_in,
  output logic                  ser_out,
  input  logic [ADDR_W-1:0]     par_addr,
  input  logic [CODE_W-1:0]     par_data,
  input  logic                  update,
  output logic [N_OUT*N_IN-1:0] xpt_en,
  output logic [N_OUT-1:0]      out_en
);
  logic [TOT-1:0] stage_q;
  logic [TOT-1:0] latch_q;

  xpt_stage #(.N_OUT(N_OUT), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst(rst), .ce(ce), .ser_mode(ser_mode), .ser_in(ser_in),
    .update(update), .par_addr(par_addr), .par_data(par_data),
    .stage_q(stage_q), .ser_out(ser_out)
  );

  xpt_latch #(.WIDTH(TOT)) u_latch (
    .clk(clk), .rst(rst), .ce(ce), .update(update),
    .stage_q(stage_q), .latch_q(latch_q)
  );

  xpt_decode #(.N_OUT(N_OUT), .N_IN(N_IN), .SEL_W(SEL_W)) u_decode (
    .latch_q(latch_q), .xpt_en(xpt_en), .out_en(out_en)
  );

  // R9: the serial output holds while chip enable is low
  a_r9_ser_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(ser_out));
endmodule

// File: tb/xpt_ctrl_tb_top.sv
module xpt_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b0;
  logic        ser_mode = 1'b0;
  logic        ser_in = 1'b0;
  logic [2:0]  par_addr = '0;
  logic [3:0]  par_data = '0;
  logic        update = 1'b0;
  logic        ser_out;
  logic [63:0] xpt_en;
  logic [7:0]  out_en;

  always #10 clk = ~clk;

  xpt_ctrl dut_i (
    .clk(clk), .rst(rst), .ce(ce), .ser_mode(ser_mode), .ser_in(ser_in),
    .ser_out(ser_out), .par_addr(par_addr), .par_data(par_data),
    .update(update), .xpt_en(xpt_en), .out_en(out_en)
  );

  typedef struct {
    logic [63:0] xpt;
    logic [7:0]  oen;
    logic        so;
    string       tag;
  } exp_t;

  exp_t q[$];
  int tests = 0;
  int fails = 0;
  logic [31:0] m_stage = '0;
  logic [31:0] m_latch = '0;
  bit done = 0;

  function automatic logic [63:0] exp_xpt(input logic [31:0] l);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++)
      if (l[4*k+3]) r[8*k + int'(l[4*k +: 3])] = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] exp_oen(input logic [31:0] l);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = l[4*k+3];
    return r;
  endfunction

  task automatic push_exp(input string tag);
    exp_t e;
    e.xpt = exp_xpt(m_latch);
    e.oen = exp_oen(m_latch);
    e.so  = m_stage[31];
    e.tag = tag;
    q.push_back(e);
  endtask

  // one clock of stimulus, then the expected port state is queued
  task automatic step(input logic c, input logic m, input logic si,
                      input logic [2:0] a, input logic [3:0] d,
                      input logic u, input string tag);
    @(negedge clk);
    ce = c; ser_mode = m; ser_in = si; par_addr = a; par_data = d; update = u;
    @(posedge clk);
    if (c && u) m_latch = m_stage;
    else if (c && m) m_stage = {m_stage[30:0], si};
    else if (c) m_stage[4*a +: 4] = d;
    #1 push_exp(tag);
  endtask

  task automatic shift_word(input logic [31:0] w, input logic c, input string tag);
    for (int b = 31; b >= 0; b--) step(c, 1'b1, w[b], 3'd0, 4'd0, 1'b0, tag);
  endtask

  // monitor: compare the ports with the oldest expected item
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      if (xpt_en !== e.xpt || out_en !== e.oen || ser_out !== e.so) begin
        fails++;
        $display("FAIL %s: xpt_en=%h out_en=%h ser_out=%b expected xpt_en=%h out_en=%h ser_out=%b",
                 e.tag, xpt_en, out_en, ser_out, e.xpt, e.oen, e.so);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w1;
    logic [31:0] w2;
    // R1: reset state
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 push_exp("R1 during reset");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1 push_exp("R1 after reset");

    // R2 / R5: serial load, outputs stay off until update
    for (int k = 0; k < 8; k++) w1[4*k +: 4] = {1'b1, 3'(7 - k)};
    shift_word(w1, 1'b1, "R2 R5 serial load");
    // R6 / R7: update exposes the anti-diagonal routing
    step(1'b1, 1'b1, 1'b1, 3'd0, 4'd0, 1'b1, "R6 R7 update serial word");

    // R3: next word pushes the first word out on ser_out in order
    w2 = 32'h9C3A_E1B5;
    shift_word(w2, 1'b1, "R3 daisy chain out");
    step(1'b1, 1'b0, 1'b0, 3'd0, 4'd0, 1'b1, "R6 R7 R8 update mixed word");

    // R4 / R8: parallel writes to single fields
    step(1'b1, 1'b0, 1'b0, 3'd3, 4'h5, 1'b0, "R4 write out3 disabled");
    step(1'b1, 1'b0, 1'b0, 3'd6, 4'hA, 1'b0, "R4 write out6 input2");
    step(1'b1, 1'b0, 1'b0, 3'd0, 4'hF, 1'b0, "R4 write out0 input7");
    step(1'b1, 1'b0, 1'b0, 3'd7, 4'h0, 1'b0, "R4 R3 write out7 msb");
    step(1'b1, 1'b0, 1'b0, 3'd2, 4'h0, 1'b1, "R6 R8 update after writes");

    // R9: chip enable low blocks everything
    shift_word(32'hFFFF_FFFF, 1'b0, "R9 shift ignored");
    step(1'b0, 1'b0, 1'b0, 3'd1, 4'hC, 1'b0, "R9 write ignored");
    step(1'b0, 1'b0, 1'b0, 3'd1, 4'hC, 1'b1, "R9 update ignored");
    step(1'b1, 1'b0, 1'b0, 3'd1, 4'hC, 1'b1, "R9 R6 stage intact");

    // R1: reset again clears routing
    @(negedge clk); rst = 1'b1; ce = 1'b0; update = 1'b0;
    @(posedge clk); m_stage = '0; m_latch = '0; #1 push_exp("R1 second reset");
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule